// File: doc/BRIEF.md
# Video Memory Bank Mapper

The mapper decides which of nine physical video memory banks backs each slot of a set of logical windows: a primary background window, a primary sprite window, a secondary background window, a secondary sprite window, a direct processor access window and four extended-palette windows. Each bank has its own 8-bit control byte. Writing a new byte to a bank first releases the slots that the bank's previous setting covered, clearing only those that the bank still owns. It then claims the slots that the new setting describes. Slots in the background, sprite and processor windows are 16 KiB units. Slots in the extended-palette windows are 8 KiB palette units.

A lookup port takes a window code and a slot number and returns, in the same cycle, the owning bank and a valid bit. Ownership is held in a table of owner entries, one for each existing slot. This table is what gives "last writer wins" its meaning, and it is why a release leaves a slot alone when that slot has since been taken by another bank. The bank storage arrays and the data path are outside this block.

Top module: `vbm_mapper`

## Requirements
- R1: After reset every control byte is zero and every query returns q_valid=0 with q_bank=0.
- R2: Control byte fields: mode = bits 2:0, offset = bits 4:3, enable = bit 7. A byte with bit 7 clear leaves the bank owning no slot once its old slots are released.
- R3: A write of the value the bank already holds changes nothing, even if other banks have since taken its slots.
- R4: On a changed write, each slot of the bank's previous setting is cleared only if the bank still owns it. Slots taken over by another bank keep their owner, and a bank that lost slots does not regain them.
- R5: Background and sprite placement: the first slot is fixed per bank and mode, indexed by the offset field. Banks 0-3 in mode 1 start at 0, 8, 16 or 24 and cover 8 slots.
- R6: Mode 0 places a bank in the processor window at its fixed base (banks 0..8: 0, 8, 16, 24, 32, 36, 37, 38, 40), covering its size in 16 KiB units (8, 8, 8, 8, 4, 1, 1, 2, 1). The span repeats every CPU_PERIOD slots from the base up to slot 63.
- R7: Extended-palette modes: bank 4 mode 4 takes palette slots 0-3 of window 5. Banks 5 and 6 in mode 4 take 2 slots starting at 0 (offset bit 3 clear) or 2 (set). Banks 5/6 in mode 5 take slot 0 of window 6, bank 7 in mode 2 takes slots 0-3 of window 7, and bank 8 in mode 3 takes slot 0 of window 8.
- R8: A mode not listed for a bank (for example mode 3 on banks 0-4, or mode 2 with offset 2 or 3 on banks 0-1) leaves the bank unmapped after release.
- R9: When several banks cover the same slot, the most recently written bank owns it.
- R10: Window codes: 0 primary background (32 slots), 1 primary sprite (16), 2 secondary background (8), 3 secondary sprite (8), 4 processor (64), 5 primary background palette (4), 6 primary sprite palette (1), 7 secondary background palette (4), 8 secondary sprite palette (1). A query with a code of 9 or above, a slot beyond the window size, or an unowned slot returns q_valid=0 and q_bank=0. Lookups are combinational and reflect a write from the clock edge that takes it.
- R11: A write with a bank index of 9 or above has no effect.
- R12: Remaining modes: banks 0/1 mode 2 go to window 1 at 0 or 8 (8 slots). Bank 2 mode 4 goes to window 2 at 0 and bank 3 mode 4 to window 3 at 0 (8 slots). Bank 4 in mode 1 or 2 goes to window 0 or 1 at 0 (4 slots). Banks 5/6 in mode 1 or 2 go to window 0 or 1 at slot 0, 1, 4 or 5 by offset. Bank 7 mode 1 goes to window 2 at 0 (2 slots). Bank 8 goes to window 2 slot 2 in mode 1 and to window 3 slot 0 in mode 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_bank | input | 4 | Bank index of the write |
| wr_ctl | input | 8 | Control byte value |
| q_region | input | 4 | Window code of the query |
| q_slot | input | 6 | Slot number within the window |
| q_valid | output | 1 | Queried slot has an owner |
| q_bank | output | 4 | Owning bank index, zero when not valid |

## Verification
On every cycle, the assertions check that an entry holds still when no changed write arrives, and that a release never touches a slot owned by some other bank. They also check that a live decode always has its enable bit set and fits inside its window, and that out-of-window queries and illegal bank numbers never come back valid. Only the bench scenarios can show the full effect of a write sequence. These include last-writer priority across overlapping banks, slots lost to a newer writer not coming back, same-value rewrites having no effect, processor-window mirroring, and the per-bank offset choices. The bench shows these by sweeping every window and slot against a behavioural ownership model.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

    localparam int NBANK  = 9;
    localparam int NREG   = 9;
    localparam int NSLOT  = 64;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int BANK_W = 4;
    localparam int REG_W  = 4;
    localparam int CNT_W  = 4;
    localparam int PER_W  = SLOT_W + 1;

    typedef enum logic [REG_W-1:0] {
        RG_BG_A   = 4'd0,
        RG_SPR_A  = 4'd1,
        RG_BG_B   = 4'd2,
        RG_SPR_B  = 4'd3,
        RG_CPU    = 4'd4,
        RG_XBG_A  = 4'd5,
        RG_XSPR_A = 4'd6,
        RG_XBG_B  = 4'd7,
        RG_XSPR_B = 4'd8
    } region_e;

    typedef struct packed {
        logic              live;
        region_e           region;
        logic [SLOT_W-1:0] first;
        logic [CNT_W-1:0]  count;
        logic [PER_W-1:0]  period;
    } span_t;

    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
    } owner_t;

    function automatic int region_slots(input int r);
        case (r)
            0:       return 32;
            1:       return 16;
            2, 3:    return 8;
            4:       return 64;
            5, 7:    return 4;
            6, 8:    return 1;
            default: return 0;
        endcase
    endfunction

    // Bank size in 16 KiB units
    function automatic logic [CNT_W-1:0] bank_units(input logic [BANK_W-1:0] b);
        case (b)
            4'd0, 4'd1, 4'd2, 4'd3: return 4'd8;
            4'd4:                   return 4'd4;
            4'd7:                   return 4'd2;
            default:                return 4'd1;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] cpu_base(input logic [BANK_W-1:0] b);
        case (b)
            4'd0:    return 6'd0;
            4'd1:    return 6'd8;
            4'd2:    return 6'd16;
            4'd3:    return 6'd24;
            4'd4:    return 6'd32;
            4'd5:    return 6'd36;
            4'd6:    return 6'd37;
            4'd7:    return 6'd38;
            default: return 6'd40;
        endcase
    endfunction

    function automatic span_t decode_span(input logic [BANK_W-1:0] b,
                                          input logic [7:0]        ctl,
                                          input logic [PER_W-1:0]  cpu_per);
        span_t      s;
        logic [2:0] m;
        logic [1:0] o;
        s        = '0;
        s.period = PER_W'(NSLOT);
        s.count  = bank_units(b);
        m        = ctl[2:0];
        o        = ctl[4:3];
        if (m == 3'd0) begin
            s.live   = 1'b1;
            s.region = RG_CPU;
            s.first  = cpu_base(b);
            s.period = cpu_per;
        end else begin
            case (b)
                4'd0, 4'd1: begin
                    if (m == 3'd1) begin
                        s.live = 1'b1; s.region = RG_BG_A; s.first = 6'({o, 3'b000});
                    end else if (m == 3'd2 && !o[1]) begin
                        s.live = 1'b1; s.region = RG_SPR_A; s.first = 6'({o[0], 3'b000});
                    end
                end
                4'd2, 4'd3: begin
                    if (m == 3'd1) begin
                        s.live = 1'b1; s.region = RG_BG_A; s.first = 6'({o, 3'b000});
                    end else if (m == 3'd4) begin
                        s.live = 1'b1; s.region = (b == 4'd2) ? RG_BG_B : RG_SPR_B;
                    end
                end
                4'd4: begin
                    if (m == 3'd1) begin
                        s.live = 1'b1; s.region = RG_BG_A;
                    end else if (m == 3'd2) begin
                        s.live = 1'b1; s.region = RG_SPR_A;
                    end else if (m == 3'd4) begin
                        s.live = 1'b1; s.region = RG_XBG_A; s.count = 4'd4;
                    end
                end
                4'd5, 4'd6: begin
                    if (m == 3'd1 || m == 3'd2) begin
                        s.live   = 1'b1;
                        s.region = (m == 3'd1) ? RG_BG_A : RG_SPR_A;
                        s.first  = 6'({o[1], 1'b0, o[0]});
                    end else if (m == 3'd4) begin
                        s.live = 1'b1; s.region = RG_XBG_A; s.count = 4'd2;
                        s.first = 6'({o[0], 1'b0});
                    end else if (m == 3'd5) begin
                        s.live = 1'b1; s.region = RG_XSPR_A; s.count = 4'd1;
                    end
                end
                4'd7: begin
                    if (m == 3'd1) begin
                        s.live = 1'b1; s.region = RG_BG_B;
                    end else if (m == 3'd2) begin
                        s.live = 1'b1; s.region = RG_XBG_B; s.count = 4'd4;
                    end
                end
                4'd8: begin
                    if (m == 3'd1) begin
                        s.live = 1'b1; s.region = RG_BG_B; s.first = 6'd2;
                    end else if (m == 3'd2) begin
                        s.live = 1'b1; s.region = RG_SPR_B;
                    end else if (m == 3'd3) begin
                        s.live = 1'b1; s.region = RG_XSPR_B; s.count = 4'd1;
                    end
                end
                default: s.live = 1'b0;
            endcase
        end
        if (!ctl[7] || b >= BANK_W'(NBANK)) s.live = 1'b0;
        return s;
    endfunction

    // Does span s cover local slot l of window r (period is a power of two)
    function automatic logic span_hits(input span_t s, input logic [REG_W-1:0] r,
                                       input logic [SLOT_W-1:0] l);
        logic [SLOT_W-1:0] diff;
        logic [SLOT_W-1:0] mask;
        diff = l - s.first;
        mask = SLOT_W'(s.period - PER_W'(1));
        return s.live && (REG_W'(s.region) == r) && (l >= s.first) &&
               ((diff & mask) < SLOT_W'(s.count));
    endfunction

endpackage

// File: rtl/vbm_ctl_bank.sv
module vbm_ctl_bank
    import vbm_pkg::*;
#(
    parameter int CPU_PERIOD = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wr_bank_i,
    input  logic [7:0]        wr_ctl_i,
    output logic              upd_o,
    output span_t             old_span_o,
    output span_t             new_span_o
);
    localparam logic [PER_W-1:0] CPU_PER = PER_W'(CPU_PERIOD);

    logic [7:0] ctl_q [NBANK];
    logic       bank_ok;
    logic [7:0] cur_ctl;

    always_comb begin
        bank_ok = (wr_bank_i < BANK_W'(NBANK));
        cur_ctl = bank_ok ? ctl_q[wr_bank_i] : 8'h00;
        upd_o   = wr_en_i && bank_ok && (wr_ctl_i != cur_ctl);
        old_span_o = decode_span(wr_bank_i, cur_ctl, CPU_PER);
        new_span_o = decode_span(wr_bank_i, wr_ctl_i, CPU_PER);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBANK; i++) ctl_q[i] <= 8'h00;
        end else if (upd_o) begin
            ctl_q[wr_bank_i] <= wr_ctl_i;
        end
    end

    AST_LIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        new_span_o.live |-> wr_ctl_i[7]); // R2

    AST_SPAN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (new_span_o.live && new_span_o.region != RG_CPU) |->
        (int'(new_span_o.first) + int'(new_span_o.count) <= region_slots(int'(new_span_o.region)))); // R5

endmodule

// File: rtl/vbm_slot_cell.sv
module vbm_slot_cell
    import vbm_pkg::*;
#(
    parameter int REGION = 0,
    parameter int INDEX  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  span_t             old_span_i,
    input  span_t             new_span_i,
    output owner_t            own_o
);
    localparam logic [REG_W-1:0]  MY_REG  = REG_W'(REGION);
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(INDEX);

    owner_t own_q;
    logic   hit_old;
    logic   hit_new;

    always_comb begin
        hit_old = span_hits(old_span_i, MY_REG, MY_SLOT);
        hit_new = span_hits(new_span_i, MY_REG, MY_SLOT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
        end else if (upd_i) begin
            if (hit_new)
                own_q <= '{valid: 1'b1, bank: bank_i};
            else if (hit_old && own_q.valid && own_q.bank == bank_i)
                own_q <= '0;
        end
    end

    assign own_o = own_q;

    AST_HOLD_WITHOUT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(own_q)); // R3

    AST_FOREIGN_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && own_q.valid && own_q.bank != bank_i && !hit_new) |=> $stable(own_q)); // R4

endmodule

// File: rtl/vbm_slot_array.sv
module vbm_slot_array
    import vbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  span_t             old_span_i,
    input  span_t             new_span_i,
    output owner_t            own_o [NREG][NSLOT]
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        for (genvar l = 0; l < NSLOT; l++) begin : g_slot
            if (l < region_slots(r)) begin : g_cell
                vbm_slot_cell #(.REGION(r), .INDEX(l)) u_cell (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .upd_i      (upd_i),
                    .bank_i     (bank_i),
                    .old_span_i (old_span_i),
                    .new_span_i (new_span_i),
                    .own_o      (own_o[r][l])
                );
            end else begin : g_none
                assign own_o[r][l] = '0;
            end
        end
    end
endmodule

// File: rtl/vbm_lookup.sv
module vbm_lookup
    import vbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  owner_t            own_i [NREG][NSLOT],
    input  logic [REG_W-1:0]  q_region_i,
    input  logic [SLOT_W-1:0] q_slot_i,
    output logic              q_valid_o,
    output logic [BANK_W-1:0] q_bank_o
);
    owner_t ent;

    always_comb begin
        ent = '0;
        if (q_region_i < REG_W'(NREG)) ent = own_i[q_region_i][q_slot_i];
        q_valid_o = ent.valid;
        q_bank_o  = ent.valid ? ent.bank : '0;
    end

    AST_OUTSIDE_WINDOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_region_i >= REG_W'(NREG)) || (int'(q_slot_i) >= region_slots(int'(q_region_i))))
        |-> !q_valid_o); // R10

    AST_OWNER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid_o |-> (q_bank_o < BANK_W'(NBANK))); // R11

endmodule

// File: rtl/vbm_mapper.sv
module vbm_mapper
    import vbm_pkg::*;
#(
    parameter int CPU_PERIOD = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_bank,
    input  logic [7:0] wr_ctl,
    input  logic [3:0] q_region,
    input  logic [5:0] q_slot,
    output logic       q_valid,
    output logic [3:0] q_bank
);
    logic   upd;
    span_t  old_span;
    span_t  new_span;
    owner_t own [NREG][NSLOT];

    vbm_ctl_bank #(.CPU_PERIOD(CPU_PERIOD)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_bank_i  (wr_bank),
        .wr_ctl_i   (wr_ctl),
        .upd_o      (upd),
        .old_span_o (old_span),
        .new_span_o (new_span)
    );

    vbm_slot_array u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (upd),
        .bank_i     (wr_bank),
        .old_span_i (old_span),
        .new_span_i (new_span),
        .own_o      (own)
    );

    vbm_lookup u_look (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_i      (own),
        .q_region_i (q_region),
        .q_slot_i   (q_slot),
        .q_valid_o  (q_valid),
        .q_bank_o   (q_bank)
    );

endmodule

// File: tb/tb_vbm_mapper.sv
module tb_vbm_mapper;
    localparam int CPU_P = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_bank = '0;
    logic [7:0] wr_ctl = '0;
    logic [3:0] q_region = '0;
    logic [5:0] q_slot = '0;
    logic       q_valid;
    logic [3:0] q_bank;

    vbm_mapper #(.CPU_PERIOD(CPU_P)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_ctl(wr_ctl),
        .q_region(q_region), .q_slot(q_slot), .q_valid(q_valid), .q_bank(q_bank)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int ov [9][64];
    int ob [9][64];
    int cm [9];

    function automatic int rsize(input int r);
        case (r)
            0: return 32;  1: return 16;  2: return 8;  3: return 8;  4: return 64;
            5: return 4;   6: return 1;   7: return 4;  8: return 1;
            default: return 0;
        endcase
    endfunction

    // Behavioural decode taken from the requirement text
    task automatic decode_m(input int b, input int c, output int live, output int rg,
                            output int first, output int cnt, output int per);
        int units [9];
        int base [9];
        int m;
        int o;
        units = '{8, 8, 8, 8, 4, 1, 1, 2, 1};
        base  = '{0, 8, 16, 24, 32, 36, 37, 38, 40};
        m = c & 7;
        o = (c >> 3) & 3;
        live = 1; rg = 0; first = 0; cnt = units[b]; per = 64;
        if (m == 0) begin rg = 4; first = base[b]; per = CPU_P; end
        else if (b <= 3 && m == 1) first = 8 * o;
        else if (b <= 1 && m == 2 && o < 2) begin rg = 1; first = 8 * o; end
        else if (b == 2 && m == 4) rg = 2;
        else if (b == 3 && m == 4) rg = 3;
        else if (b == 4 && (m == 1 || m == 2)) rg = m - 1;
        else if (b == 4 && m == 4) begin rg = 5; cnt = 4; end
        else if ((b == 5 || b == 6) && (m == 1 || m == 2)) begin rg = m - 1; first = (o & 1) + 4 * (o >> 1); end
        else if ((b == 5 || b == 6) && m == 4) begin rg = 5; cnt = 2; first = 2 * (o & 1); end
        else if ((b == 5 || b == 6) && m == 5) begin rg = 6; cnt = 1; end
        else if (b == 7 && m == 1) rg = 2;
        else if (b == 7 && m == 2) begin rg = 7; cnt = 4; end
        else if (b == 8 && m == 1) begin rg = 2; first = 2; end
        else if (b == 8 && m == 2) rg = 3;
        else if (b == 8 && m == 3) begin rg = 8; cnt = 1; end
        else live = 0;
        if ((c & 8'h80) == 0) live = 0;
    endtask

    task automatic model_write(input int b, input int c);
        int live, rg, first, cnt, per;
        if (b > 8) return;
        if (c == cm[b]) return;
        decode_m(b, cm[b], live, rg, first, cnt, per);
        if (live != 0)
            for (int j = first; j < rsize(rg); j += per)
                for (int i = 0; i < cnt; i++)
                    if (j + i < rsize(rg) && ov[rg][j+i] != 0 && ob[rg][j+i] == b) begin
                        ov[rg][j+i] = 0; ob[rg][j+i] = 0;
                    end
        decode_m(b, c, live, rg, first, cnt, per);
        if (live != 0)
            for (int j = first; j < rsize(rg); j += per)
                for (int i = 0; i < cnt; i++)
                    if (j + i < rsize(rg)) begin
                        ov[rg][j+i] = 1; ob[rg][j+i] = b;
                    end
        cm[b] = c;
    endtask

    task automatic wr(input int b, input int c);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = b[3:0]; wr_ctl = c[7:0];
        @(posedge clk);
        model_write(b, c);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input int r, input int s);
        int ev, eb;
        string t;
        @(negedge clk);
        q_region = r[3:0]; q_slot = s[5:0];
        #2;
        if (r < 9 && s < rsize(r)) begin ev = ov[r][s]; eb = ob[r][s]; t = tag; end
        else begin ev = 0; eb = 0; t = "R10"; end
        n_chk++;
        if (int'(q_valid) != ev || int'(q_bank) != eb) begin
            n_err++;
            $display("FAIL %s region=%0d slot=%0d got valid=%0d bank=%0d expected valid=%0d bank=%0d",
                     t, r, s, q_valid, q_bank, ev, eb);
        end
    endtask

    task automatic sweep(input string tag);
        for (int r = 0; r < 11; r++)
            for (int s = 0; s < 64; s++)
                chk(tag, (r == 10) ? 15 : r, s);
    endtask

    initial begin
        for (int r = 0; r < 9; r++) begin
            cm[r] = 0;
            for (int s = 0; s < 64; s++) begin ov[r][s] = 0; ob[r][s] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        sweep("R1");
        // enable bit and background offsets
        wr(0, 'h01);  sweep("R2");
        wr(0, 'h81);  sweep("R5");
        wr(0, 'h91);  sweep("R5");
        wr(0, 'h99);  sweep("R5");
        // priority, same-value rewrite, conditional release
        wr(4, 'h81);  wr(0, 'h81);  sweep("R9");
        wr(4, 'h81);  sweep("R3");
        wr(5, 'h89);  sweep("R9");
        wr(0, 'h00);  sweep("R4");
        // undefined modes
        wr(1, 'h81);  wr(1, 'h83);  wr(4, 'h86);  wr(0, 'h92);  sweep("R8");
        // processor window with mirroring
        wr(0, 'h80);  wr(2, 'h80);  wr(4, 'h80);  wr(7, 'h80);  wr(8, 'h80);  sweep("R6");
        // extended palettes
        wr(4, 'h84);  sweep("R7");
        wr(6, 'h8C);  wr(5, 'h84);  sweep("R7");
        wr(5, 'h85);  wr(7, 'h82);  wr(8, 'h83);  sweep("R7");
        // illegal bank index
        wr(9, 'h81);  wr(15, 'h84);  sweep("R11");
        // remaining mode table entries
        wr(2, 'h84);  wr(3, 'h84);  wr(8, 'h82);  wr(7, 'h81);  sweep("R12");
        wr(8, 'h81);  wr(0, 'h8A);  wr(5, 'h8A);  wr(6, 'h91);  sweep("R12");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog got running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule